// File: doc/BRIEF.md
# Default-Master Backplane Arbiter

This block decides who drives a shared backplane when the board's own processor is the normal owner and external masters may borrow the bus. While no external master is asking, the processor runs freely and holds the backplane with no handshake. An external master signals its interest on an active-low request line. The arbiter then asserts the processor's active-low halt input.

The arbiter watches the processor's two bus-status outputs. It hands out an active-low grant only once both outputs read high, which shows that the processor has let go of the bus. A single grant is held for as long as its owner keeps requesting. When that request is withdrawn, the grant is removed. Halt is released one clock later, and the processor resumes as the default master.

Requests arrive asynchronously and are brought into the clock domain through a two-flop synchroniser. The board reset is asserted asynchronously and released synchronously. All outputs come straight from flops.

Top module: `bkpl_arbiter`

## Requirements
- R1: While reset is asserted, and after reset until a request is seen, halt_n is 1 and gnt_n is all ones.
- R2: A request held low is first seen by the control logic two clocks after it is presented. halt_n goes low on the third rising edge after the request is presented, and is still high after the second.
- R3: No grant is issued unless cpu_ba and cpu_bs are both 1 while halt is asserted. With any other status value, gnt_n stays all ones for as long as the request lasts.
- R4: Once the processor reports halted, the grant is driven on the next rising edge to the requester that asked. Bit i of gnt_n low means requester i owns the bus, and halt_n stays low throughout the tenure.
- R5: When both requests are pending as the grant is decided, requester 0 (bit 0) wins.
- R6: While the owner keeps requesting, the grant does not move, even if the other requester asserts.
- R7: When the owner withdraws its request, its grant is removed on the third rising edge. halt_n returns high on the following edge.
- R8: With no request pending, halt_n stays high and gnt_n stays all ones, whatever cpu_ba and cpu_bs show.
- R9: At most one bit of gnt_n is low at any time.
- R10: If a request is withdrawn before any grant is issued, halt_n returns high on the third rising edge after the withdrawal, and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| req_n | input | 2 | Active-low bus requests from the external masters, bit 0 has the highest priority |
| cpu_ba | input | 1 | Processor bus-available status output |
| cpu_bs | input | 1 | Processor bus-state status output |
| halt_n | output | 1 | Active-low halt input of the processor |
| gnt_n | output | 2 | Active-low bus grants, one per requester |

## Verification
The bench sweeps every combination of the two request lines against every combination of the two status bits. This separates three outcomes: halting with no grant (status not yet halted), granting the single requester that asked, and granting by priority when both ask. In each case it samples halt one edge before and on the edge it must change, so a synchroniser of the wrong depth is caught. Withdrawal is checked both from a granted and from a still-halting state, which distinguishes the grant-drop step from the direct halt release. A separate sequence asserts the higher-priority request during a low-priority tenure. It shows that the grant holds, then passes over only after the owner leaves and the processor has had one free cycle.

// File: rtl/bkpl_arb_pkg.sv
package bkpl_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HALT = 2'd1,
    ARB_OWN  = 2'd2,
    ARB_DROP = 2'd3
  } arb_state_e;
endpackage

// File: rtl/bkpl_rst_sync.sv
module bkpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bkpl_req_sync.sv
module bkpl_req_sync #(
  parameter int NUM_REQ = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_n,
  output logic [NUM_REQ-1:0] req_act
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_ch
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], req_n[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign req_act[g] = ~sh_q[STAGES-1];
  end
endmodule

// File: rtl/bkpl_arb_ctrl.sv
module bkpl_arb_ctrl
  import bkpl_arb_pkg::*;
#(
  parameter int NUM_REQ = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_act,
  input  logic               cpu_ba,
  input  logic               cpu_bs,
  output logic               halt_q,
  output logic [NUM_REQ-1:0] gnt_q
);
  arb_state_e         state_q, state_d;
  logic [NUM_REQ-1:0] gnt_d;
  logic               halt_d;
  logic [NUM_REQ-1:0] pick;
  logic               cpu_off_bus;

  assign cpu_off_bus = cpu_ba & cpu_bs;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req_act[i]) pick = NUM_REQ'(1) << i;
    end
  end

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    unique case (state_q)
      ARB_IDLE: if (|req_act) state_d = ARB_HALT;
      ARB_HALT: begin
        if (!(|req_act)) begin
          state_d = ARB_IDLE;
        end else if (cpu_off_bus) begin
          state_d = ARB_OWN;
          gnt_d   = pick;
        end
      end
      ARB_OWN: begin
        if (!(|(gnt_q & req_act))) begin
          state_d = ARB_DROP;
          gnt_d   = '0;
        end
      end
      ARB_DROP: state_d = ARB_IDLE;
      default:  state_d = ARB_IDLE;
    endcase
    halt_d = (state_d != ARB_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      halt_q  <= halt_d;
    end
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R3
  grant_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_q) && !(|$past(gnt_q))) |-> $past(cpu_ba && cpu_bs && halt_q));

  // R4
  grant_under_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_q) |-> halt_q);

  // R6
  grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_q) && (|$past(gnt_q))) |-> (gnt_q == $past(gnt_q)));

  // R7
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> ($past(gnt_q) == '0));
endmodule

// File: rtl/bkpl_arbiter.sv
module bkpl_arbiter #(
  parameter int NUM_REQ     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_n,
  input  logic               cpu_ba,
  input  logic               cpu_bs,
  output logic               halt_n,
  output logic [NUM_REQ-1:0] gnt_n
);
  logic               rst_core_n;
  logic [NUM_REQ-1:0] req_act;
  logic               halt_q;
  logic [NUM_REQ-1:0] gnt_q;

  bkpl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  bkpl_req_sync #(.NUM_REQ(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .req_n(req_n), .req_act(req_act)
  );

  bkpl_arb_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .req_act(req_act),
    .cpu_ba(cpu_ba), .cpu_bs(cpu_bs), .halt_q(halt_q), .gnt_q(gnt_q)
  );

  assign halt_n = ~halt_q;
  assign gnt_n  = ~gnt_q;
endmodule

// File: tb/bkpl_arbiter_bench.sv
module bkpl_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] req_n;
  logic       cpu_ba, cpu_bs;
  logic       halt_n;
  logic [1:0] gnt_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bkpl_arbiter u_bkpl_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cpu_ba(cpu_ba),
    .cpu_bs(cpu_bs), .halt_n(halt_n), .gnt_n(gnt_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {halt_n,gnt_n} actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    req_n  = 2'b11;
    rst_n  = 1'b0;
    tick(2);
    // R1
    chk("R1", {halt_n, gnt_n}, 3'b111);
    rst_n = 1'b1;
    tick(4);
    chk("R1", {halt_n, gnt_n}, 3'b111);
  endtask

  initial begin
    rst_n = 1'b0; req_n = 2'b11; cpu_ba = 1'b0; cpu_bs = 1'b0;
    tick(1);
    for (int pat = 0; pat < 4; pat++) begin
      for (int st = 0; st < 4; st++) begin
        logic [1:0] win;
        logic       granted;
        logic       any;
        do_reset();
        any     = (pat != 0);
        win     = pat[0] ? 2'b01 : (pat[1] ? 2'b10 : 2'b00);
        granted = any && (st == 3);
        {cpu_ba, cpu_bs} = st[1:0];
        req_n = ~pat[1:0];
        tick(2);
        // R2 not yet visible
        chk("R2", {halt_n, gnt_n}, 3'b111);
        tick(1);
        // R2 / R8
        chk(any ? "R2" : "R8", {halt_n, gnt_n}, {~any, 2'b11});
        tick(1);
        // R3 / R4 / R5
        chk(pat == 3 ? "R5" : (granted ? "R4" : "R3"), {halt_n, gnt_n},
            {~any, granted ? ~win : 2'b11});
        tick(5);
        chk(granted ? "R4" : "R3", {halt_n, gnt_n},
            {~any, granted ? ~win : 2'b11});
        req_n = 2'b11;
        tick(2);
        chk(granted ? "R7" : "R10", {halt_n, gnt_n},
            {~any, granted ? ~win : 2'b11});
        tick(1);
        // R7 grant gone, R10 halt released
        chk(granted ? "R7" : "R10", {halt_n, gnt_n}, {~granted, 2'b11});
        tick(1);
        chk(granted ? "R7" : "R10", {halt_n, gnt_n}, 3'b111);
      end
    end

    // R6: low-priority tenure not preempted
    do_reset();
    {cpu_ba, cpu_bs} = 2'b11;
    req_n = 2'b01;
    tick(4);
    chk("R6", {halt_n, gnt_n}, 3'b001);
    req_n = 2'b00;
    tick(6);
    chk("R6", {halt_n, gnt_n}, 3'b001);
    req_n = 2'b10;
    tick(3);
    chk("R7", {halt_n, gnt_n}, 3'b011);
    tick(1);
    chk("R7", {halt_n, gnt_n}, 3'b111);
    tick(1);
    chk("R2", {halt_n, gnt_n}, 3'b011);
    tick(1);
    chk("R5", {halt_n, gnt_n}, 3'b010);

    // R3: status arrives late, grant follows next edge
    do_reset();
    {cpu_ba, cpu_bs} = 2'b10;
    req_n = 2'b10;
    tick(8);
    chk("R3", {halt_n, gnt_n}, 3'b011);
    cpu_bs = 1'b1;
    tick(1);
    chk("R4", {halt_n, gnt_n}, 3'b010);
    req_n = 2'b11;
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    tick(20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule